// File: doc/BRIEF.md
# Hard-Decision Trellis Add-Compare-Select Core

This block is the arithmetic heart of a hard-decision maximum-likelihood decoder for a rate 1/2, constraint length 3 convolutional code. For each accepted 2-bit received symbol it forms the Hamming distance to all four possible code pairs. In the same cycle it extends the survivor of each of the four trellis states from its two predecessors and keeps the cheaper one. It then renormalises the state metrics so that they stay inside a fixed 5-bit range.

For every step it emits one decision bit per state, naming which predecessor won. It also emits the index of the state that now holds the smallest metric, which a downstream traceback unit can use as its starting point. Survivor storage and traceback live outside this block.

Both edges are valid/ready streams. A symbol is consumed on a clock edge where `sym_valid` and `sym_ready` are both high. A result is consumed on an edge where `res_valid` and `res_ready` are both high. The core holds one result. It can take a new symbol whenever that slot is empty or is being drained in the same cycle, so `sym_ready` is `!res_valid || res_ready`. While a result sits unconsumed, the result and the state metrics are frozen, and the symbol input is ignored.

Top module: `vit_acs_core`

## Requirements
- R1: After reset `res_valid` is 0 and `sym_ready` is 1. State 0 starts with metric 0 and every other state starts with metric 31, so the first decisions and the first minimum index follow from those values.
- R2: `sym_in[1]` is the received bit of generator 7 (octal) and `sym_in[0]` the bit of generator 5. Let the encoder register be {new bit u, state bit 1, state bit 0}, where state bit 1 is the newer of the two stored bits. The expected pair for a branch is {u^s1^s0, u^s0}. The branch cost is the number of differing bits, 0 to 2.
- R3: Next state n = {u, m} has predecessors {m,0} and {m,1}. Its new metric is the smaller of the two (predecessor metric + branch cost) sums. Decision bit n of `res_dec` is 1 only when predecessor {m,1} is strictly cheaper; a tie gives 0.
- R4: After each update the minimum of the four candidate metrics is subtracted from all of them, so at least one stored metric is always 0.
- R5: A normalised metric above 31 is clamped to 31.
- R6: `res_min` is the lowest-numbered state whose updated metric is 0.
- R7: A symbol accepted on edge k produces `res_valid`=1 with its decisions from edge k onward. With `res_ready`=1 and no new symbol, `res_valid` falls on the next edge.
- R8: While `res_valid`=1 and `res_ready`=0, `sym_ready` is 0. In that state `res_dec`, `res_min` and the metrics hold, and any presented symbol has no effect.
- R9: Fed an error-free encoding of any bit stream that starts from state 0, `res_min` equals the encoder's state after each symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | Received symbol present |
| sym_ready | output | 1 | Core can accept a symbol |
| sym_in | input | 2 | Hard received pair, bit 1 from generator 7, bit 0 from generator 5 |
| res_valid | output | 1 | Decision vector and minimum index are valid |
| res_ready | input | 1 | Consumer takes the result |
| res_dec | output | 4 | One survivor decision bit per state |
| res_min | output | 2 | Index of the state with the smallest metric |

## Verification
The bench runs every 4-symbol sequence from reset, then a long pseudo-random stream and a clean encoded stream, all against an arithmetic trellis model. The 4-symbol sweep hits the start-up clamp: the first steps from states held at 31 produce sums of 33. A core that wraps instead of clamping would show a small metric and soon pick the wrong predecessors and minimum state. Random streams hit many equal candidate sums. Resolving ties toward the odd predecessor, or reporting the highest zero-metric state, shows up as flipped decision bits or a wrong `res_min`. A stall test changes the symbol while the output is blocked. Any core that consumed it would drift from the model on the following steps, and any that dropped its held result would change `res_dec` during the stall.

// File: rtl/vit_pkg.sv
package vit_pkg;

  // Parity of the taps selected from an encoder register value.
  function automatic int tap_parity(input int taps, input int regv, input int k);
    int acc;
    acc = 0;
    for (int b = 0; b < k; b++) begin
      if (((taps >> b) & 1) == 1 && ((regv >> b) & 1) == 1) acc = acc ^ 1;
    end
    return acc;
  endfunction

  // Code pair emitted when bit u enters an encoder sitting in state pred.
  // The state's MSB is the newer stored bit.
  function automatic int branch_pair(input int g_hi, input int g_lo, input int k,
                                     input int u, input int pred);
    int regv;
    regv = (u << (k - 1)) | pred;
    return (tap_parity(g_hi, regv, k) << 1) | tap_parity(g_lo, regv, k);
  endfunction

endpackage

// File: rtl/vit_bmu.sv
module vit_bmu #(
  parameter int SYMW = 2,
  parameter int BMW  = 2
) (
  input  logic [SYMW-1:0]                 sym,
  output logic [(1<<SYMW)-1:0][BMW-1:0]   bm
);
  localparam int NP = 1 << SYMW;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    always_comb bm[p] = BMW'($countones(sym ^ SYMW'(p)));
  end
endmodule

// File: rtl/vit_acs_unit.sv
module vit_acs_unit #(
  parameter int K     = 3,
  parameter int G_HI  = 7,
  parameter int G_LO  = 5,
  parameter int SMW   = 5,
  parameter int BMW   = 2,
  parameter int STATE = 0
) (
  input  logic [(1<<(K-1))-1:0][SMW-1:0] sm_all,
  input  logic [3:0][BMW-1:0]            bm,
  output logic [SMW:0]                   cand,
  output logic                           dec
);
  localparam int U   = STATE >> (K - 2);
  localparam int LOW = STATE % (1 << (K - 2));
  localparam int P0  = LOW * 2;
  localparam int P1  = P0 + 1;
  localparam int E0  = vit_pkg::branch_pair(G_HI, G_LO, K, U, P0);
  localparam int E1  = vit_pkg::branch_pair(G_HI, G_LO, K, U, P1);

  logic [SMW:0] c0, c1;

  always_comb begin
    c0 = {1'b0, sm_all[P0]} + (SMW+1)'(bm[E0]);
    c1 = {1'b0, sm_all[P1]} + (SMW+1)'(bm[E1]);
    if (c1 < c0) begin
      cand = c1;
      dec  = 1'b1;
    end else begin
      cand = c0;
      dec  = 1'b0;
    end
  end
endmodule

// File: rtl/vit_norm.sv
module vit_norm #(
  parameter int NS  = 4,
  parameter int SMW = 5,
  parameter int SW  = 2
) (
  input  logic [NS-1:0][SMW:0]   raw,
  output logic [NS-1:0][SMW-1:0] nrm,
  output logic [SW-1:0]          min_idx
);
  localparam logic [SMW:0] MAXM = (SMW+1)'((1 << SMW) - 1);

  logic [SMW:0] mv;
  logic [SMW:0] diff [NS];

  always_comb begin
    mv      = raw[0];
    min_idx = '0;
    for (int i = 1; i < NS; i++) begin
      if (raw[i] < mv) begin
        mv      = raw[i];
        min_idx = SW'(i);
      end
    end
    for (int i = 0; i < NS; i++) begin
      diff[i] = raw[i] - mv;
      nrm[i]  = (diff[i] > MAXM) ? MAXM[SMW-1:0] : diff[i][SMW-1:0];
    end
  end
endmodule

// File: rtl/vit_acs_core.sv
module vit_acs_core #(
  parameter int K    = 3,
  parameter int G_HI = 7,
  parameter int G_LO = 5,
  parameter int SMW  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sym_valid,
  output logic                  sym_ready,
  input  logic [1:0]            sym_in,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [(1<<(K-1))-1:0] res_dec,
  output logic [K-2:0]          res_min
);
  localparam int NS  = 1 << (K - 1);
  localparam int SW  = K - 1;
  localparam int BMW = 2;
  localparam logic [SMW-1:0] MAXM = SMW'((1 << SMW) - 1);

  logic [NS-1:0][SMW-1:0] sm_q;
  logic [NS-1:0][SMW-1:0] sm_nrm;
  logic [NS-1:0][SMW:0]   cand;
  logic [NS-1:0]          dec;
  logic [3:0][BMW-1:0]    bm;
  logic [SW-1:0]          midx;
  logic                   take;

  vit_bmu #(.SYMW(2), .BMW(BMW)) u_bmu (.sym(sym_in), .bm(bm));

  for (genvar s = 0; s < NS; s++) begin : g_acs
    vit_acs_unit #(
      .K(K), .G_HI(G_HI), .G_LO(G_LO), .SMW(SMW), .BMW(BMW), .STATE(s)
    ) u_acs (
      .sm_all(sm_q), .bm(bm), .cand(cand[s]), .dec(dec[s])
    );
  end

  vit_norm #(.NS(NS), .SMW(SMW), .SW(SW)) u_norm (
    .raw(cand), .nrm(sm_nrm), .min_idx(midx)
  );

  assign sym_ready = !res_valid || res_ready;
  assign take      = sym_valid && sym_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) sm_q[s] <= (s == 0) ? '0 : MAXM;
      res_valid <= 1'b0;
      res_dec   <= '0;
      res_min   <= '0;
    end else if (take) begin
      sm_q      <= sm_nrm;
      res_dec   <= dec;
      res_min   <= midx;
      res_valid <= 1'b1;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  logic [NS-1:0] sm_zero;
  for (genvar s = 0; s < NS; s++) begin : g_zero
    assign sm_zero[s] = (sm_q[s] == '0);
  end

  // R7: an accepted symbol yields a valid result on the next edge
  p_accept_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> res_valid);

  // R7: a drained result with no new symbol clears the valid flag
  p_idle_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !sym_valid) |=> !res_valid);

  // R8: a blocked result holds, and so do the metrics
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_dec) &&
                                   $stable(res_min) && $stable(sm_q)));

  // R8: no symbol is taken while the result slot is blocked
  p_stall_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !sym_ready);

  // R4: normalisation keeps one metric at zero
  p_norm_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sm_zero != '0);

  // R6: the reported state carries the zero metric
  p_min_metric_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> sm_zero[res_min]);
endmodule

// File: tb/tb_vit_acs_core.sv
module tb_vit_acs_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic       res_ready = 1'b1;
  logic [1:0] sym_in = '0;
  logic       sym_ready, res_valid;
  logic [3:0] res_dec;
  logic [1:0] res_min;

  int n_chk = 0;
  int n_fail = 0;
  int mdl [4];
  int exp_dec [4];
  int exp_min;
  logic [15:0] lf = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  vit_acs_core dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_in(sym_in), .res_valid(res_valid), .res_ready(res_ready),
    .res_dec(res_dec), .res_min(res_min)
  );

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int code_pair(input int u, input int p);
    int r1, r0;
    r1 = (p >> 1) & 1;
    r0 = p & 1;
    return ((u ^ r1 ^ r0) << 1) | (u ^ r0);
  endfunction

  function automatic int hdist(input int a, input int b);
    int x;
    x = a ^ b;
    return (x & 1) + ((x >> 1) & 1);
  endfunction

  task automatic model_step(input int sym);
    int nm [4];
    int mn, u, p0, c0, c1;
    for (int n = 0; n < 4; n++) begin
      u  = n >> 1;
      p0 = (n & 1) << 1;
      c0 = mdl[p0] + hdist(sym, code_pair(u, p0));
      c1 = mdl[p0+1] + hdist(sym, code_pair(u, p0 + 1));
      if (c1 < c0) begin nm[n] = c1; exp_dec[n] = 1; end
      else begin nm[n] = c0; exp_dec[n] = 0; end
    end
    mn = nm[0];
    for (int n = 1; n < 4; n++) if (nm[n] < mn) mn = nm[n];
    exp_min = -1;
    for (int n = 0; n < 4; n++) begin
      mdl[n] = nm[n] - mn;
      if (mdl[n] > 31) mdl[n] = 31;
      if (mdl[n] == 0 && exp_min < 0) exp_min = n;
    end
  endtask

  function automatic int dec_word();
    return exp_dec[0] | (exp_dec[1] << 1) | (exp_dec[2] << 2) | (exp_dec[3] << 3);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    sym_valid = 1'b0;
    res_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mdl = '{0, 31, 31, 31};
    @(negedge clk);
  endtask

  // Present a symbol at a falling edge; it is taken on the next rising edge.
  task automatic send_chk(input int sym, input string req);
    sym_valid = 1'b1;
    sym_in = sym[1:0];
    model_step(sym);
    @(negedge clk);
    check({req, " valid"}, int'(res_valid), 1);
    check({req, " dec"}, int'(res_dec), dec_word());
    check({req, " min"}, int'(res_min), exp_min);
  endtask

  function automatic void lf_step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1: idle outputs after reset
    check("R1 res_valid", int'(res_valid), 0);
    check("R1 sym_ready", int'(sym_ready), 1);
    // R1 R5: first step from the initial metrics, including clamped sums
    send_chk(3, "R1");
    send_chk(0, "R5");
    sym_valid = 1'b0;
    @(negedge clk);
    check("R7 drop", int'(res_valid), 0);

    // R2 R3 R4 R5 R6: every 4-symbol sequence from reset
    for (int seq = 0; seq < 256; seq++) begin
      do_reset();
      for (int i = 0; i < 4; i++) send_chk((seq >> (2 * i)) & 3, "R3");
      sym_valid = 1'b0;
    end

    // R3 R4 R6: long pseudo-random stream, back to back
    do_reset();
    for (int i = 0; i < 1500; i++) begin
      lf_step();
      send_chk(int'(lf[1:0]), "R6");
    end
    sym_valid = 1'b0;
    @(negedge clk);
    check("R7 idle", int'(res_valid), 0);

    // R9: error-free encoded stream, minimum state tracks the encoder
    do_reset();
    begin
      int es;
      int u;
      es = 0;
      for (int i = 0; i < 300; i++) begin
        lf_step();
        u = int'(lf[0]);
        send_chk(code_pair(u, es), "R2");
        es = (u << 1) | (es >> 1);
        check("R9 track", int'(res_min), es);
      end
    end
    sym_valid = 1'b0;

    // R8: stall with a changing symbol that must be ignored
    do_reset();
    res_ready = 1'b0;
    send_chk(1, "R8");
    for (int i = 0; i < 3; i++) begin
      sym_in = 2'(i + 1);
      @(negedge clk);
      check("R8 ready", int'(sym_ready), 0);
      check("R8 hold dec", int'(res_dec), dec_word());
      check("R8 hold min", int'(res_min), exp_min);
    end
    res_ready = 1'b1;
    send_chk(2, "R8");
    send_chk(3, "R8");
    send_chk(0, "R8");
    sym_valid = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule